// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames on one output line. A character written into the holding register is copied into a frame shifter as soon as the shifter is free. It then leaves the line framed as follows: one low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Between frames the line rests high.

The holding register and the shifter form a two-stage buffer. Software can therefore load the next character while the current one is still going out, and consecutive frames follow each other with no idle gap. All bit timing comes from an external clock-enable pulse at sixteen times the bit rate. An optional bit-rate clock output is low for the first half of each bit and high for the second half, so its rising edge falls at the centre of the bit.

Top module: `frame_tx`

## Requirements
- R1: After reset, `txLine` is high, `bitClk` is high, `holdEmpty` is 1 and `txDone` is 1.
- R2: A frame starts with a low start bit, followed by the data bits least significant first; with `charShort`=0 all 8 bits of the character are sent.
- R3: With `charShort`=1 only bits 0 to 6 are sent, and bit 7 of the character has no effect on the line.
- R4: With `parityOn`=1 a parity bit follows the data. It is computed over the sent data bits only, and makes the count of ones even when `parityOdd`=0 and odd when `parityOdd`=1.
- R5: The frame ends with one high stop bit, or two when `twoStop`=1, and the line stays high afterwards while nothing is pending.
- R6: Every bit lasts exactly 16 cycles in which `tick16` is 1. While `tick16` is 0 the line does not change.
- R7: A write clears `holdEmpty`. The transfer into the shifter sets it again and drives the start bit; from idle this happens one cycle after the write. A character pending at the end of a frame starts on the very next bit period, with no idle gap.
- R8: A write while the holding register is still full replaces the pending character; only the last one is sent.
- R9: `txDone` rises when the last stop bit completes with no character pending, and a write clears it.
- R10: With `clkOutEn`=1 and a frame in progress, `bitClk` is low for sample counts 0 to 7 of each bit and high for counts 8 to 15. It is high when the block is idle or when `clkOutEn`=0.
- R11: The format inputs (`charShort`, `parityOn`, `parityOdd`, `twoStop`) are taken at the transfer into the shifter; changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Clock-enable at 16x the bit rate |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Character to write |
| charShort | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| parityOn | input | 1 | Adds a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| twoStop | input | 1 | 1 = two stop bits, 0 = one |
| clkOutEn | input | 1 | Enables the bit-rate clock output |
| txLine | output | 1 | Serial data line |
| bitClk | output | 1 | Bit-rate clock, rising at mid-bit |
| holdEmpty | output | 1 | Holding register can take a character |
| txDone | output | 1 | Line idle, nothing pending |

## Verification
The properties assume that `tick16` is the only source of bit progress. They also assume that a write is a single-cycle pulse that may arrive at any time. The stall property further assumes that no character is pending on the cycle it covers. The bench drives every input on the falling clock edge and holds `tick16` high except in the stall scenario, so each bit is exactly 16 cycles long and can be sampled at fixed offsets from the start edge. Format inputs are changed only between frames, except in the scenario that checks they are taken at the transfer.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  // Strobes from the sequencer to the datapath, valid for one clock.
  typedef struct packed {
    logic load;     // copy holding register into the shifter
    logic advance;  // move to the next bit of the frame
    logic finish;   // last stop bit has just completed
  } txStrobe_t;

endpackage

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      holdFull,
  input  logic      charShort,
  input  logic      parityOn,
  input  logic      twoStop,
  input  logic      clkOutEn,
  output txStrobe_t strobe,
  output logic      bitClk
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int CNT_W   = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2);

  logic             busy;
  logic [CNT_W-1:0] sampleCnt;
  logic [LEN_W-1:0] bitsLeft;
  logic [LEN_W-1:0] frameLen;
  logic             advance;
  logic             finish;
  logic             load;

  // Frame length is fixed by the format at the moment of transfer.
  always_comb begin
    frameLen = LEN_W'(1 + (charShort ? DATA_W - 1 : DATA_W)
                        + (parityOn ? 1 : 0) + (twoStop ? 2 : 1));
  end

  assign advance = busy && tick16 && (sampleCnt == CNT_LAST);
  assign finish  = advance && (bitsLeft == LEN_W'(1));
  assign load    = holdFull && (!busy || finish);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      sampleCnt <= '0;
      bitsLeft  <= '0;
    end else if (load) begin
      busy      <= 1'b1;
      sampleCnt <= '0;
      bitsLeft  <= frameLen;
    end else if (finish) begin
      busy      <= 1'b0;
      sampleCnt <= '0;
      bitsLeft  <= '0;
    end else if (busy && tick16) begin
      sampleCnt <= sampleCnt + 1'b1;
      if (advance) bitsLeft <= bitsLeft - 1'b1;
    end
  end

  always_comb begin
    strobe.load    = load;
    strobe.advance = advance;
    strobe.finish  = finish;
  end

  // Low for the first half of every bit, high for the second half.
  assign bitClk = !clkOutEn || !busy || (sampleCnt >= CNT_MID);

endmodule

// File: rtl/frame_tx_dpath.sv
module frame_tx_dpath
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              charShort,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output logic              txLine,
  output logic              txDone
);

  localparam int FRAME_W = DATA_W + 4;

  logic [DATA_W-1:0]  holdReg;
  logic [DATA_W-1:0]  dataMask;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frameImg;
  logic               parityBit;
  int                 dataLen;

  // Build the frame image: start bit at position 0, stop bits come from the ones fill.
  always_comb begin
    dataLen   = charShort ? DATA_W - 1 : DATA_W;
    dataMask  = charShort ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    parityBit = parityOdd ^ (^(holdReg & dataMask));
    frameImg  = '1;
    frameImg[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dataLen) frameImg[i+1] = holdReg[i];
    end
    if (parityOn) frameImg[dataLen+1] = parityBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else begin
      if (wrEn) holdReg <= wrData;
      if (wrEn)             holdFull <= 1'b1;
      else if (strobe.load) holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               shiftReg <= '1;
    else if (strobe.load)    shiftReg <= frameImg;
    else if (strobe.advance) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              txDone <= 1'b1;
    else if (wrEn)                          txDone <= 1'b0;
    else if (strobe.finish && !strobe.load) txDone <= 1'b1;
  end

  assign txLine = shiftReg[0];

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              charShort,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              clkOutEn,
  output logic              txLine,
  output logic              bitClk,
  output logic              holdEmpty,
  output logic              txDone
);

  txStrobe_t strobe;
  logic      holdFull;

  frame_tx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick16    (tick16),
    .holdFull  (holdFull),
    .charShort (charShort),
    .parityOn  (parityOn),
    .twoStop   (twoStop),
    .clkOutEn  (clkOutEn),
    .strobe    (strobe),
    .bitClk    (bitClk)
  );

  frame_tx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .charShort (charShort),
    .parityOn  (parityOn),
    .parityOdd (parityOdd),
    .strobe    (strobe),
    .holdFull  (holdFull),
    .txLine    (txLine),
    .txDone    (txDone)
  );

  assign holdEmpty = !holdFull;

endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
  input logic clk,
  input logic rstN,
  input logic tick16,
  input logic wrEn,
  input logic txLine,
  input logic bitClk,
  input logic holdEmpty,
  input logic txDone
);

  p_idle_mark_r5: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txLine);

  p_idle_clk_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> bitClk);

  p_write_clears_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !txDone);

  p_done_needs_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> holdEmpty);

  p_no_tick_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!tick16 && holdEmpty && !wrEn) |=> $stable(txLine));

  p_transfer_starts_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> !txLine);

endmodule

bind frame_tx frame_tx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick16    (tick16),
  .wrEn      (wrEn),
  .txLine    (txLine),
  .bitClk    (bitClk),
  .holdEmpty (holdEmpty),
  .txDone    (txDone)
);

// File: tb/tb_frame_tx.sv
module tb_frame_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickOn = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       charShort = 1'b0, parityOn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic       clkOutEn = 1'b1;
  logic       txLine, bitClk, holdEmpty, txDone;
  int         nChecks = 0, nFails = 0, cycles = 0;

  always #10 clk = ~clk;

  frame_tx dut (
    .clk(clk), .rstN(rstN), .tick16(tickOn), .wrEn(wrEn), .wrData(wrData),
    .charShort(charShort), .parityOn(parityOn), .parityOdd(parityOdd),
    .twoStop(twoStop), .clkOutEn(clkOutEn), .txLine(txLine), .bitClk(bitClk),
    .holdEmpty(holdEmpty), .txDone(txDone)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeChar(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  // Samples each bit at count 4 (clock low) and count 8 (data, clock high).
  task automatic decodeFrame(input logic [7:0] d, input bit shortC, input bit par,
                             input bit odd, input bit two, input bit chained,
                             input bit clkExp, input string req);
    int bits[12];
    int n = 0;
    int dl = shortC ? 7 : 8;
    bit p = odd;
    bits[n++] = 0;
    for (int i = 0; i < dl; i++) begin bits[n++] = d[i]; p ^= d[i]; end
    if (par) bits[n++] = p;
    bits[n++] = 1;
    if (two) bits[n++] = 1;
    if (!chained) begin @(negedge txLine); @(negedge clk); end
    else repeat (8) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      repeat (4) @(negedge clk);
      chk(bitClk == (clkExp ? 1'b0 : 1'b1), "R10", "bitClk early half", bitClk, clkExp ? 0 : 1);
      repeat (4) @(negedge clk);
      chk(txLine == bits[k], req, $sformatf("frame bit %0d", k), txLine, bits[k]);
      chk(bitClk == 1'b1, "R10", "bitClk mid-bit", bitClk, 1);
      if (k < n - 1) repeat (8) @(negedge clk);
    end
  endtask

  task automatic checkEnd();
    chk(txDone == 1'b0, "R9", "txDone during stop", txDone, 0);
    repeat (8) @(negedge clk);
    chk(txDone == 1'b1, "R9", "txDone after frame", txDone, 1);
    chk(txLine == 1'b1, "R5", "line idle high", txLine, 1);
  endtask

  task automatic t_reset();
    chk(txLine == 1'b1, "R1", "line", txLine, 1);
    chk(bitClk == 1'b1, "R1", "bitClk", bitClk, 1);
    chk(holdEmpty == 1'b1, "R1", "holdEmpty", holdEmpty, 1);
    chk(txDone == 1'b1, "R1", "txDone", txDone, 1);
  endtask

  task automatic t_basic();
    fork
      decodeFrame(8'hA5, 0, 0, 0, 0, 0, 1, "R2");
      begin
        writeChar(8'hA5);
        chk(holdEmpty == 1'b0, "R7", "holdEmpty after write", holdEmpty, 0);
        chk(txDone == 1'b0, "R9", "txDone cleared by write", txDone, 0);
        @(negedge clk);
        chk(holdEmpty == 1'b1, "R7", "holdEmpty after transfer", holdEmpty, 1);
        chk(txLine == 1'b0, "R7", "start bit at transfer", txLine, 0);
      end
    join
    checkEnd();
  endtask

  task automatic t_short();
    charShort = 1'b1; parityOn = 1'b1; parityOdd = 1'b0;
    fork
      decodeFrame(8'hD3, 1, 1, 0, 0, 0, 1, "R3");
      writeChar(8'hD3);
    join
    checkEnd();
    fork
      decodeFrame(8'h53, 1, 1, 0, 0, 0, 1, "R3");
      writeChar(8'h53);
    join
    checkEnd();
    charShort = 1'b0; parityOn = 1'b0;
  endtask

  task automatic t_parity();
    parityOn = 1'b1; parityOdd = 1'b1; twoStop = 1'b1;
    fork
      decodeFrame(8'h3C, 0, 1, 1, 1, 0, 1, "R4");
      writeChar(8'h3C);
    join
    checkEnd();
    parityOdd = 1'b0;
    fork
      decodeFrame(8'h07, 0, 1, 0, 1, 0, 1, "R4");
      writeChar(8'h07);
    join
    checkEnd();
    parityOn = 1'b0; twoStop = 1'b0;
  endtask

  task automatic t_backToBack();
    fork
      begin
        decodeFrame(8'h81, 0, 0, 0, 0, 0, 1, "R7");
        decodeFrame(8'h7E, 0, 0, 0, 0, 1, 1, "R7");
      end
      begin
        writeChar(8'h81);
        wait (holdEmpty);
        writeChar(8'h7E);
      end
    join
    checkEnd();
  endtask

  task automatic t_overwrite();
    fork
      begin
        decodeFrame(8'h11, 0, 0, 0, 0, 0, 1, "R8");
        decodeFrame(8'hC6, 0, 0, 0, 0, 1, 1, "R8");
      end
      begin
        writeChar(8'h11);
        wait (holdEmpty);
        writeChar(8'h99);
        writeChar(8'hC6);
      end
    join
    checkEnd();
  endtask

  task automatic t_latched();
    fork
      decodeFrame(8'h5A, 0, 0, 0, 0, 0, 1, "R11");
      begin
        writeChar(8'h5A);
        repeat (3) @(negedge clk);
        charShort = 1'b1; parityOn = 1'b1; twoStop = 1'b1;
      end
    join
    checkEnd();
    charShort = 1'b0; parityOn = 1'b0; twoStop = 1'b0;
  endtask

  task automatic t_clkOff();
    clkOutEn = 1'b0;
    fork
      decodeFrame(8'hF0, 0, 0, 0, 0, 0, 0, "R10");
      writeChar(8'hF0);
    join
    checkEnd();
    clkOutEn = 1'b1;
  endtask

  task automatic t_stall();
    logic lineHeld, clkHeld;
    bit   steady = 1'b1;
    fork
      begin @(negedge txLine); repeat (20) @(negedge clk); end
      writeChar(8'h00);
    join
    tickOn = 1'b0;
    @(negedge clk);
    lineHeld = txLine; clkHeld = bitClk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txLine !== lineHeld || bitClk !== clkHeld) steady = 1'b0;
    end
    chk(steady, "R6", "line frozen without tick", steady, 1);
    tickOn = 1'b1;
    for (int i = 0; i < 400 && !txDone; i++) @(negedge clk);
    chk(txDone == 1'b1, "R6", "frame completes after resume", txDone, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_short();
    t_parity();
    t_backToBack();
    t_overwrite();
    t_latched();
    t_clkOff();
    t_stall();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule